// File: doc/BRIEF.md
# Asynchronous Serial Transceiver with Strobed Character Format

This block sends and receives asynchronous serial characters on a single transmit line and a single receive line. Both directions share one character format, held in a five-bit control register that a bus write loads. The format selects 5 to 8 data bits, parity on or off, odd or even parity, and one or two stop bits. With 5-bit characters the two-stop setting gives one and a half stop bits.

A processor drives the block through a small register map addressed by `bus_addr`. The writable addresses are the control register, the transmit holding register, a strobe that clears the data-ready flag, and a strobe that resets the block without touching the format. The readable addresses return a status byte and the last received character. Bit timing comes from `tick16`, a one-cycle enable that pulses sixteen times per bit period. The block does not divide the clock to make a baud rate.

Top module: `strobed_uart`

## Requirements
- R1: The character length is 5 + fmt[1] + 2*fmt[2] data bits, sent and received LSB first. A received character is right-justified in the 8-bit data read (address 1), with the unused upper bits zero.
- R2: A frame is one start bit, the data bits, an optional parity bit, and the stop time, with each bit lasting 16 ticks. When fmt[3]=0 the stop time is 16 ticks. When fmt[3]=1 it is 32 ticks, or 24 ticks for 5-bit characters. Back-to-back characters follow each other with no idle ticks between them.
- R3: When fmt[4]=1 no parity bit is sent or checked. Otherwise a parity bit follows the data. With fmt[0]=1 the parity is even (the XOR of the data bits). With fmt[0]=0 it is odd (the inverse of that XOR).
- R4: A write to address 4 latches bus_wdata[4:0] as the format. After rst_n the format is 5'b10110: 8 data bits, no parity, one stop bit.
- R5: A status read (address 0) returns bit0 = transmit holding empty, bit1 = data ready, bit2 = overrun, bit3 = framing error, bit4 = parity error, and bits 7:5 = 1. After reset it reads 8'hE1.
- R6: A write to address 6 clears data ready.
- R7: A write to address 7 returns the transmitter, the receiver, the received data and all flags to their reset state. The format register keeps its value.
- R8: The receiver checks the start bit at its midpoint, 8 ticks after the falling edge. If the line is high again at that point, the receiver ignores the pulse and no character is received.
- R9: If the line is low at the midpoint of the first stop bit, the character is still delivered and the framing-error flag is set.
- R10: If a character completes while data ready is still set, the overrun flag is set and the new character replaces the old one.
- R11: If parity is enabled and the received parity bit does not match the selected sense, the parity-error flag is set.
- R12: A write to address 5 loads the transmit holding register and clears the holding-empty flag. The flag sets again when the character moves to the shifter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; also clears the format register to its default |
| tick16 | input | 1 | Bit-clock enable, 16 pulses per bit |
| bus_wr | input | 1 | Write strobe for the register at bus_addr |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| rxd | input | 1 | Serial receive line, idle high |
| txd | output | 1 | Serial transmit line, idle high |

## Verification
The main sweep runs all 32 format codes with the transmit line looped back to the receiver. Each code sends two characters back to back, with payload bytes that vary by code. The spacing between the two holding-register unloads measures the frame length, so a wrong stop time or a missing parity slot shows up as a cycle-count mismatch. The bench samples the transmit line at the middle of the parity slot; this catches inverted parity sense and a parity bit sent while parity is off. The received bytes, masked to the character length, show whether the length decode and right-justification are correct. For the receiver's error paths, the bench drives the receive line by hand: a short low pulse that must be rejected, a frame with a low stop bit, and a frame with wrong parity. Two unread characters check overrun. A chip reset under a 5-bit, one-and-a-half-stop format then shows the format surviving the reset.

// File: rtl/suart_pkg.sv
package suart_pkg;

  // Format register: field positions are decoded by the tx and rx engines.
  typedef struct packed {
    logic no_par;    // bit 4
    logic stop_x;    // bit 3
    logic len_w2;    // bit 2, weight 2
    logic len_w1;    // bit 1, weight 1
    logic par_even;  // bit 0
  } fmt_t;

  localparam fmt_t FMT_DEFAULT = '{no_par: 1'b1, stop_x: 1'b0, len_w2: 1'b1,
                                   len_w1: 1'b1, par_even: 1'b0};

  typedef enum logic [2:0] {PH_IDLE, PH_START, PH_DATA, PH_PAR, PH_STOP} phase_t;

  localparam logic [2:0] A_STATUS = 3'd0;
  localparam logic [2:0] A_RXDATA = 3'd1;
  localparam logic [2:0] A_CTRL   = 3'd4;
  localparam logic [2:0] A_TXDATA = 3'd5;
  localparam logic [2:0] A_DRCLR  = 3'd6;
  localparam logic [2:0] A_SRST   = 3'd7;

  function automatic logic [3:0] char_len(input logic w2, input logic w1);
    return 4'd5 + {3'b000, w1} + {2'b00, w2, 1'b0};
  endfunction

  function automatic logic [7:0] len_mask(input logic [3:0] len);
    return 8'hFF >> (4'd8 - len);
  endfunction

endpackage

// File: rtl/suart_tx.sv
module suart_tx
  import suart_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       tick,
  input  fmt_t       fmt,
  input  logic       wr_stb,
  input  logic [7:0] wr_data,
  output logic       empty,
  output logic       txd
);

  localparam int CW = $clog2(2 * OVS);
  localparam logic [CW-1:0] BIT_LAST   = CW'(OVS - 1);
  localparam logic [CW-1:0] STOP1_LAST = CW'(OVS - 1);
  localparam logic [CW-1:0] STOP3_LAST = CW'(OVS + OVS / 2 - 1);
  localparam logic [CW-1:0] STOP2_LAST = CW'(2 * OVS - 1);

  phase_t        ph_q, ph_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [2:0]    idx_q, idx_d;
  logic [7:0]    sh_q, sh_d;
  logic          par_q, par_d;
  logic [7:0]    hold_q, hold_d;
  logic          full_q, full_d;

  logic [3:0]    len;
  logic [2:0]    last_idx;
  logic [7:0]    masked;
  logic [CW-1:0] stop_last;
  logic          load;

  assign len       = char_len(fmt.len_w2, fmt.len_w1);
  assign last_idx  = 3'(len - 4'd1);
  assign masked    = hold_q & len_mask(len);
  assign stop_last = !fmt.stop_x ? STOP1_LAST : ((len == 4'd5) ? STOP3_LAST : STOP2_LAST);

  always_comb begin
    ph_d   = ph_q;
    cnt_d  = cnt_q;
    idx_d  = idx_q;
    sh_d   = sh_q;
    par_d  = par_q;
    hold_d = hold_q;
    full_d = full_q;
    load   = 1'b0;
    if (tick) begin
      unique case (ph_q)
        PH_IDLE:  load = full_q;
        PH_START: begin
          if (cnt_q == '0) begin
            ph_d  = PH_DATA;
            cnt_d = BIT_LAST;
            idx_d = '0;
          end else cnt_d = cnt_q - 1'b1;
        end
        PH_DATA: begin
          if (cnt_q == '0) begin
            sh_d  = sh_q >> 1;
            cnt_d = BIT_LAST;
            if (idx_q == last_idx) begin
              ph_d = fmt.no_par ? PH_STOP : PH_PAR;
              if (fmt.no_par) cnt_d = stop_last;
            end else idx_d = idx_q + 3'd1;
          end else cnt_d = cnt_q - 1'b1;
        end
        PH_PAR: begin
          if (cnt_q == '0) begin
            ph_d  = PH_STOP;
            cnt_d = stop_last;
          end else cnt_d = cnt_q - 1'b1;
        end
        PH_STOP: begin
          if (cnt_q == '0) begin
            if (full_q) load = 1'b1;
            else        ph_d = PH_IDLE;
          end else cnt_d = cnt_q - 1'b1;
        end
        default: ph_d = PH_IDLE;
      endcase
    end
    if (load) begin
      ph_d   = PH_START;
      cnt_d  = BIT_LAST;
      sh_d   = masked;
      par_d  = fmt.par_even ? (^masked) : ~(^masked);
      full_d = 1'b0;
    end
    if (wr_stb) begin
      hold_d = wr_data;
      full_d = 1'b1;
    end
    if (clr) begin
      ph_d   = PH_IDLE;
      cnt_d  = '0;
      idx_d  = '0;
      sh_d   = '0;
      par_d  = 1'b0;
      hold_d = '0;
      full_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      idx_q  <= '0;
      sh_q   <= '0;
      par_q  <= 1'b0;
      hold_q <= '0;
      full_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      cnt_q  <= cnt_d;
      idx_q  <= idx_d;
      sh_q   <= sh_d;
      par_q  <= par_d;
      hold_q <= hold_d;
      full_q <= full_d;
    end
  end

  always_comb begin
    unique case (ph_q)
      PH_START: txd = 1'b0;
      PH_DATA:  txd = sh_q[0];
      PH_PAR:   txd = par_q;
      default:  txd = 1'b1;
    endcase
  end

  assign empty = ~full_q;

endmodule

// File: rtl/suart_rx.sv
module suart_rx
  import suart_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       tick,
  input  logic       no_par,
  input  logic       par_even,
  input  logic [3:0] len,
  input  logic       rxd,
  output logic       done,
  output logic [7:0] dout,
  output logic       stop_bad,
  output logic       par_bad
);

  localparam int CW = $clog2(2 * OVS);
  localparam logic [CW-1:0] BIT_LAST  = CW'(OVS - 1);
  localparam logic [CW-1:0] HALF_LAST = CW'(OVS / 2 - 1);

  logic          sync1_q, sync2_q;
  phase_t        ph_q, ph_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [2:0]    idx_q, idx_d;
  logic [7:0]    sh_q, sh_d;
  logic          pbit_q, pbit_d;
  logic          done_q, done_d;
  logic          sbad_q, sbad_d;
  logic          pbad_q, pbad_d;
  logic [2:0]    last_idx;
  logic          exp_par;

  assign last_idx = 3'(len - 4'd1);
  assign exp_par  = par_even ? (^sh_q) : ~(^sh_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b1;
      sync2_q <= 1'b1;
    end else begin
      sync1_q <= rxd;
      sync2_q <= sync1_q;
    end
  end

  always_comb begin
    ph_d   = ph_q;
    cnt_d  = cnt_q;
    idx_d  = idx_q;
    sh_d   = sh_q;
    pbit_d = pbit_q;
    done_d = 1'b0;
    sbad_d = sbad_q;
    pbad_d = pbad_q;
    if (tick) begin
      unique case (ph_q)
        PH_IDLE: begin
          if (!sync2_q) begin
            ph_d  = PH_START;
            cnt_d = HALF_LAST;
          end
        end
        PH_START: begin
          if (cnt_q == '0) begin
            if (!sync2_q) begin
              ph_d  = PH_DATA;
              cnt_d = BIT_LAST;
              idx_d = '0;
              sh_d  = '0;
            end else ph_d = PH_IDLE;
          end else cnt_d = cnt_q - 1'b1;
        end
        PH_DATA: begin
          if (cnt_q == '0) begin
            sh_d[idx_q] = sync2_q;
            cnt_d       = BIT_LAST;
            if (idx_q == last_idx) ph_d = no_par ? PH_STOP : PH_PAR;
            else                   idx_d = idx_q + 3'd1;
          end else cnt_d = cnt_q - 1'b1;
        end
        PH_PAR: begin
          if (cnt_q == '0) begin
            pbit_d = sync2_q;
            ph_d   = PH_STOP;
            cnt_d  = BIT_LAST;
          end else cnt_d = cnt_q - 1'b1;
        end
        PH_STOP: begin
          if (cnt_q == '0) begin
            done_d = 1'b1;
            sbad_d = ~sync2_q;
            pbad_d = ~no_par & (pbit_q != exp_par);
            ph_d   = PH_IDLE;
          end else cnt_d = cnt_q - 1'b1;
        end
        default: ph_d = PH_IDLE;
      endcase
    end
    if (clr) begin
      ph_d   = PH_IDLE;
      cnt_d  = '0;
      idx_d  = '0;
      sh_d   = '0;
      pbit_d = 1'b0;
      done_d = 1'b0;
      sbad_d = 1'b0;
      pbad_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      idx_q  <= '0;
      sh_q   <= '0;
      pbit_q <= 1'b0;
      done_q <= 1'b0;
      sbad_q <= 1'b0;
      pbad_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      cnt_q  <= cnt_d;
      idx_q  <= idx_d;
      sh_q   <= sh_d;
      pbit_q <= pbit_d;
      done_q <= done_d;
      sbad_q <= sbad_d;
      pbad_q <= pbad_d;
    end
  end

  assign done     = done_q;
  assign dout     = sh_q;
  assign stop_bad = sbad_q;
  assign par_bad  = pbad_q;

endmodule

// File: rtl/strobed_uart.sv
module strobed_uart
  import suart_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick16,
  input  logic       bus_wr,
  input  logic [2:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       rxd,
  output logic       txd
);

  fmt_t       ctrl_q, ctrl_d;
  logic [7:0] rdat_q, rdat_d;
  logic       dr_q, dr_d;
  logic       ovr_q, ovr_d;
  logic       fe_q, fe_d;
  logic       pe_q, pe_d;

  logic       soft_clr, dr_clr, tx_wr;
  logic       tx_empty;
  logic       rx_done, rx_fbad, rx_pbad;
  logic [7:0] rx_data;

  assign soft_clr = bus_wr && (bus_addr == A_SRST);
  assign dr_clr   = bus_wr && (bus_addr == A_DRCLR);
  assign tx_wr    = bus_wr && (bus_addr == A_TXDATA);

  suart_tx #(.OVS(OVS)) u_tx (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (soft_clr),
    .tick    (tick16),
    .fmt     (ctrl_q),
    .wr_stb  (tx_wr),
    .wr_data (bus_wdata),
    .empty   (tx_empty),
    .txd     (txd)
  );

  suart_rx #(.OVS(OVS)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (soft_clr),
    .tick     (tick16),
    .no_par   (ctrl_q.no_par),
    .par_even (ctrl_q.par_even),
    .len      (char_len(ctrl_q.len_w2, ctrl_q.len_w1)),
    .rxd      (rxd),
    .done     (rx_done),
    .dout     (rx_data),
    .stop_bad (rx_fbad),
    .par_bad  (rx_pbad)
  );

  always_comb begin
    ctrl_d = ctrl_q;
    rdat_d = rdat_q;
    dr_d   = dr_q;
    ovr_d  = ovr_q;
    fe_d   = fe_q;
    pe_d   = pe_q;
    if (bus_wr && (bus_addr == A_CTRL)) ctrl_d = fmt_t'(bus_wdata[4:0]);
    if (dr_clr) dr_d = 1'b0;
    if (rx_done) begin
      rdat_d = rx_data;
      dr_d   = 1'b1;
      ovr_d  = dr_q;
      fe_d   = rx_fbad;
      pe_d   = rx_pbad;
    end
    if (soft_clr) begin
      rdat_d = '0;
      dr_d   = 1'b0;
      ovr_d  = 1'b0;
      fe_d   = 1'b0;
      pe_d   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= FMT_DEFAULT;
      rdat_q <= '0;
      dr_q   <= 1'b0;
      ovr_q  <= 1'b0;
      fe_q   <= 1'b0;
      pe_q   <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      rdat_q <= rdat_d;
      dr_q   <= dr_d;
      ovr_q  <= ovr_d;
      fe_q   <= fe_d;
      pe_q   <= pe_d;
    end
  end

  always_comb begin
    unique case (bus_addr)
      A_STATUS: bus_rdata = {3'b111, pe_q, fe_q, ovr_q, dr_q, tx_empty};
      A_RXDATA: bus_rdata = rdat_q;
      default:  bus_rdata = 8'hFF;
    endcase
  end

endmodule

// File: rtl/strobed_uart_chk.sv
module strobed_uart_chk
  import suart_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       bus_wr,
  input logic [2:0] bus_addr,
  input logic       dr,
  input logic       ovr,
  input logic       tx_empty,
  input logic [4:0] ctrl,
  input logic       rx_done
);

  // R6
  dr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_DRCLR && !rx_done) |=> !dr);

  // R7
  soft_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_SRST) |=> (tx_empty && !dr && !ovr));

  // R7
  fmt_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_SRST) |=> $stable(ctrl));

  // R10
  overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && dr && !(bus_wr && bus_addr == A_SRST)) |=> ovr);

  // R12
  hold_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_TXDATA) |=> !tx_empty);

endmodule

bind strobed_uart strobed_uart_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .dr       (dr_q),
  .ovr      (ovr_q),
  .tx_empty (tx_empty),
  .ctrl     (ctrl_q),
  .rx_done  (rx_done)
);

// File: tb/strobed_uart_test.sv
module strobed_uart_test;
  import suart_pkg::*;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick16 = 1'b0;
  logic       bus_wr = 1'b0;
  logic [2:0] bus_addr = 3'd0;
  logic [7:0] bus_wdata = 8'd0;
  wire  [7:0] bus_rdata;
  logic       rx_force = 1'b0;
  logic       rx_val = 1'b1;
  wire        txd;
  wire        rxd = rx_force ? rx_val : txd;

  int vectors = 0;
  int misses = 0;
  int cyc = 0;

  strobed_uart uut (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rxd(rxd), .txd(txd)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) tick16 <= ~tick16;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wait_flag(input int b, output int at);
    logic [7:0] s;
    forever begin
      bus_read(A_STATUS, s);
      if (s[b]) break;
    end
    at = cyc;
  endtask

  function automatic int nbits(input logic [4:0] f);
    return 5 + f[1] + 2 * f[2];
  endfunction

  function automatic int frame_ticks(input logic [4:0] f);
    int n = nbits(f);
    int st = f[3] ? ((n == 5) ? 24 : 32) : 16;
    return 16 * (1 + n + (f[4] ? 0 : 1)) + st;
  endfunction

  // Two back-to-back characters through the loopback path.
  task automatic send_pair(input logic [4:0] f, input logic [7:0] a,
                           input logic [7:0] b, input string tag);
    int n = nbits(f);
    logic [7:0] m = 8'hFF >> (8 - n);
    int c1, c2, t;
    logic [7:0] s, d;
    logic expb;
    bus_write(A_TXDATA, a);
    wait_flag(0, c1);
    bus_write(A_TXDATA, b);
    bus_read(A_STATUS, s);
    check(s[0] == 1'b0, {tag, " R12 holding full after write"}, s[0], 0);
    while (cyc < c1 + 2 * (16 * (1 + n) + 8)) @(negedge clk);
    expb = f[4] ? 1'b1 : (f[0] ? ^(a & m) : ~^(a & m));
    check(txd === expb, {tag, " R3 parity slot"}, txd, expb);
    wait_flag(0, c2);
    check(c2 - c1 == 2 * frame_ticks(f), {tag, " R2 frame length"}, c2 - c1, 2 * frame_ticks(f));
    wait_flag(1, t);
    bus_read(A_STATUS, s);
    check(s[7:1] == 7'b1110001, {tag, " R5 status after first char"}, s, 8'hE2);
    bus_read(A_RXDATA, d);
    check(d == (a & m), {tag, " R1 first char"}, d, a & m);
    bus_write(A_DRCLR, 8'h00);
    bus_read(A_STATUS, s);
    check(s[1] == 1'b0, {tag, " R6 data ready cleared"}, s[1], 0);
    wait_flag(1, t);
    bus_read(A_RXDATA, d);
    check(d == (b & m), {tag, " R1 second char"}, d, b & m);
    bus_read(A_STATUS, s);
    check(s[4:2] == 3'b000, {tag, " R11 R9 R10 no errors on loopback"}, s[4:2], 0);
    bus_write(A_DRCLR, 8'h00);
    repeat (100) @(negedge clk);
  endtask

  // Hand-driven frame on the receive line; pb < 0 means no parity slot.
  task automatic raw_frame(input logic [7:0] d, input int n, input int pb, input logic stopv);
    rx_force = 1'b1;
    rx_val = 1'b0; repeat (32) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      rx_val = d[i]; repeat (32) @(negedge clk);
    end
    if (pb >= 0) begin
      rx_val = pb[0]; repeat (32) @(negedge clk);
    end
    rx_val = stopv; repeat (stopv ? 32 : 24) @(negedge clk);
    rx_val = 1'b1; repeat (80) @(negedge clk);
  endtask

  initial begin
    logic [7:0] s, d;
    int t;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R5 reset state
    bus_read(A_STATUS, s);
    check(s == 8'hE1, "R5 reset status", s, 8'hE1);

    // R4 default format 8 bits, no parity, 1 stop
    send_pair(5'b10110, 8'h81, 8'h7E, "R4");

    // Sweep of every format code
    for (int f = 0; f < 32; f++) begin
      bus_write(A_CTRL, 8'(f));
      send_pair(5'(f), 8'hA5 ^ 8'(f * 7), 8'h3C + 8'(f), "sweep");
    end

    // R8 short low pulse rejected
    bus_write(A_CTRL, 8'h16);
    rx_force = 1'b1; rx_val = 1'b0;
    repeat (6) @(negedge clk);
    rx_val = 1'b1;
    repeat (200) @(negedge clk);
    bus_read(A_STATUS, s);
    check(s[1] == 1'b0, "R8 glitch ignored", s[1], 0);

    // R9 low stop bit
    raw_frame(8'h55, 8, -1, 1'b0);
    bus_read(A_STATUS, s);
    check(s[4:1] == 4'b0101, "R9 framing flag", s[4:1], 4'b0101);
    bus_read(A_RXDATA, d);
    check(d == 8'h55, "R9 data kept", d, 8'h55);
    bus_write(A_DRCLR, 8'h00);

    // R11 wrong parity, 8 bits even
    bus_write(A_CTRL, 8'h07);
    raw_frame(8'h01, 8, 0, 1'b1);
    bus_read(A_STATUS, s);
    check(s[4:1] == 4'b1001, "R11 parity flag", s[4:1], 4'b1001);
    bus_write(A_DRCLR, 8'h00);
    raw_frame(8'h01, 8, 1, 1'b1);
    bus_read(A_STATUS, s);
    check(s[4:1] == 4'b0001, "R11 good parity", s[4:1], 4'b0001);
    bus_write(A_DRCLR, 8'h00);
    rx_force = 1'b0;

    // R10 overrun
    bus_write(A_CTRL, 8'h16);
    bus_write(A_TXDATA, 8'h11);
    wait_flag(0, t);
    bus_write(A_TXDATA, 8'h22);
    wait_flag(1, t);
    repeat (450) @(negedge clk);
    bus_read(A_STATUS, s);
    check(s[2:1] == 2'b11, "R10 overrun flag", s[2:1], 2'b11);
    bus_read(A_RXDATA, d);
    check(d == 8'h22, "R10 newest char kept", d, 8'h22);
    bus_write(A_DRCLR, 8'h00);

    // R7 chip reset keeps 5-bit, 1.5-stop format
    bus_write(A_CTRL, 8'h18);
    bus_write(A_TXDATA, 8'hFF);
    wait_flag(1, t);
    repeat (100) @(negedge clk);
    bus_write(A_SRST, 8'h00);
    bus_read(A_STATUS, s);
    check(s == 8'hE1, "R7 status after chip reset", s, 8'hE1);
    bus_read(A_RXDATA, d);
    check(d == 8'h00, "R7 data cleared", d, 0);
    send_pair(5'b11000, 8'hFF, 8'h0A, "R7");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    vectors++;
    misses++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule